// File: doc/BRIEF.md
# Control-Channel Message Receive Mailbox

The block takes a byte stream from an embedded control channel and assembles fixed-length messages of eight bytes. A message starts with a byte that carries a start-of-message marker. Each accepted byte goes into its own data register, and the processor reads all of them as one flattened bus. When the last byte of a complete message has been stored, a full flag is raised. The flag drives an interrupt when the processor has enabled it, and the processor can also poll it.

The buffer is single-entry and uses a handshake. While the full flag is set, the stored data cannot change. A message that arrives in this state is discarded in full, and a sticky overrun bit records the loss. The processor releases the buffer by pulsing a clear input. A status output tells the far end whether the buffer can accept a new message.

Top module: `ctl_msg_mailbox`

## Requirements
- R1: After reset `full_o`, `ovr_o` and `irq_o` are 0, `buf_avail_o` is 1 and every data register reads 0.
- R2: Byte k of a message is stored in data register k, which sits at `msg_data_o[8k+7:8k]`. The byte flagged with `byte_sop_i` is k = 0, and later accepted bytes count up in arrival order. Cycles with `byte_valid_i` low are skipped.
- R3: `full_o` rises in the cycle after the eighth byte of a message is accepted, and only then.
- R4: A byte with `byte_sop_i` set restarts assembly at k = 0, so an earlier unfinished message never sets `full_o`. A valid byte without `byte_sop_i` is ignored when no message is in progress, and this includes bytes that follow a completed eighth byte.
- R5: The buffer may be full when a message starts. That message is dropped in full, `msg_data_o` stays unchanged and `full_o` stays set.
- R6: A pulse on `full_clr_i` clears `full_o` in the next cycle. The next complete message is then stored.
- R7: `irq_o` is 1 exactly when `full_o` is 1 and `irq_en_i` is 1.
- R8: `buf_avail_o` is the inverse of `full_o`. It reports to the far end whether a new message can be taken.
- R9: `ovr_o` sets in the cycle after the last byte of a dropped message. It stays set through `full_clr_i` and clears only on a pulse of `ovr_clr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_valid_i | input | 1 | Stream byte valid |
| byte_sop_i | input | 1 | First byte of a message |
| byte_data_i | input | 8 | Stream byte |
| irq_en_i | input | 1 | Interrupt enable for the full flag |
| full_clr_i | input | 1 | Processor release of the buffer |
| ovr_clr_i | input | 1 | Processor clear of the overrun bit |
| msg_data_o | output | 64 | Eight data registers, register k at bits 8k+7:8k |
| full_o | output | 1 | Complete message held |
| irq_o | output | 1 | Interrupt request |
| ovr_o | output | 1 | Sticky overrun |
| buf_avail_o | output | 1 | Buffer free, sent to the far end |

## Verification
The bench sends a second message while the buffer is full. A design that wrote through to the registers would corrupt the stored data, which the scoreboard compare detects. A design that reset the flag would raise a second full event, which the bench also detects.

The bench cuts a message short and restarts it with a new start marker. It also sends stray bytes with no message in progress, and trailing bytes after a full message. A counter that failed to restart or to stop would place bytes in the wrong registers or raise the flag early.

Gaps in the valid signal check that idle cycles do not advance the byte position. The overrun bit is checked across a buffer release to confirm that it is sticky.

// File: rtl/ctl_mbx_pkg.sv
package ctl_mbx_pkg;
  localparam int unsigned MBX_NUM_BYTES = 8;
  localparam int unsigned MBX_BYTE_W    = 8;

  typedef struct packed {
    logic done;   // complete message stored
    logic drop;   // dropped message finished
  } msg_evt_t;
endpackage

// File: rtl/msg_assembler.sv
module msg_assembler #(
  parameter int unsigned NUM_BYTES = 8,
  parameter int unsigned CNT_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic                  sop_i,
  input  logic                  full_i,
  output logic                  wr_en_o,
  output logic [CNT_W-1:0]      wr_idx_o,
  output ctl_mbx_pkg::msg_evt_t evt_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_BYTES - 1);

  logic             busy_q, drop_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start, cont, take, drop_now, last;

  assign start    = valid_i & sop_i;
  assign cont     = valid_i & ~sop_i & busy_q;
  assign take     = start | cont;
  assign wr_idx_o = start ? '0 : cnt_q;
  // drop decision is latched at start of message
  assign drop_now = start ? full_i : drop_q;
  assign last     = take & (wr_idx_o == LAST_IDX);
  assign wr_en_o  = take & ~drop_now;
  assign evt_o.done = last & ~drop_now;
  assign evt_o.drop = last & drop_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      drop_q <= 1'b0;
      cnt_q  <= '0;
    end else if (take) begin
      if (last) begin
        busy_q <= 1'b0;
        drop_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        busy_q <= 1'b1;
        drop_q <= drop_now;
        cnt_q  <= wr_idx_o + 1'b1;
      end
    end
  end

  // R5: a message starting on a full buffer writes nothing
  a_r5_no_write_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && full_i) |-> !wr_en_o);
  // R4: stray byte outside a message is not taken
  a_r4_stray_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sop_i && !busy_q) |-> !wr_en_o);
endmodule

// File: rtl/msg_regs.sv
module msg_regs #(
  parameter int unsigned NUM_BYTES = 8,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned CNT_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [CNT_W-1:0]            wr_idx_i,
  input  logic [BYTE_W-1:0]           wr_data_i,
  input  logic                        full_i,
  output logic [NUM_BYTES*BYTE_W-1:0] data_o
);
  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_reg
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   q <= '0;
      else if (wr_en_i && wr_idx_i == CNT_W'(i))     q <= wr_data_i;
    end
    assign data_o[i*BYTE_W +: BYTE_W] = q;
  end

  // R5: stored message held while the flag is set
  a_r5_data_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_i |=> $stable(data_o));
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  ctl_mbx_pkg::msg_evt_t evt_i,
  input  logic                  full_clr_i,
  input  logic                  ovr_clr_i,
  input  logic                  irq_en_i,
  output logic                  full_o,
  output logic                  ovr_o,
  output logic                  irq_o
);
  logic full_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (evt_i.done)      full_q <= 1'b1;
      else if (full_clr_i) full_q <= 1'b0;
      if (evt_i.drop)      ovr_q  <= 1'b1;
      else if (ovr_clr_i)  ovr_q  <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign ovr_o  = ovr_q;
  assign irq_o  = full_q & irq_en_i;

  // R3: flag rises only after a completed message
  a_r3_full_from_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_q) |-> $past(evt_i.done));
  // R6: release clears the flag
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_clr_i && !evt_i.done) |=> !full_q);
  // R9: overrun is sticky
  a_r9_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !ovr_clr_i) |=> ovr_q);
endmodule

// File: rtl/ctl_msg_mailbox.sv
module ctl_msg_mailbox #(
  parameter int unsigned NUM_BYTES = ctl_mbx_pkg::MBX_NUM_BYTES,
  parameter int unsigned BYTE_W    = ctl_mbx_pkg::MBX_BYTE_W,
  localparam int unsigned CNT_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
  localparam int unsigned MSG_W    = NUM_BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic              byte_sop_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  input  logic              irq_en_i,
  input  logic              full_clr_i,
  input  logic              ovr_clr_i,
  output logic [MSG_W-1:0]  msg_data_o,
  output logic              full_o,
  output logic              irq_o,
  output logic              ovr_o,
  output logic              buf_avail_o
);
  logic                  wr_en;
  logic [CNT_W-1:0]      wr_idx;
  ctl_mbx_pkg::msg_evt_t evt;
  logic                  full;

  msg_assembler #(.NUM_BYTES(NUM_BYTES), .CNT_W(CNT_W)) u_asm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (byte_valid_i),
    .sop_i    (byte_sop_i),
    .full_i   (full),
    .wr_en_o  (wr_en),
    .wr_idx_o (wr_idx),
    .evt_o    (evt)
  );

  msg_regs #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (byte_data_i),
    .full_i    (full),
    .data_o    (msg_data_o)
  );

  mbx_flag u_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .full_clr_i (full_clr_i),
    .ovr_clr_i  (ovr_clr_i),
    .irq_en_i   (irq_en_i),
    .full_o     (full),
    .ovr_o      (ovr_o),
    .irq_o      (irq_o)
  );

  assign full_o      = full;
  assign buf_avail_o = ~full;

  // R8: far-end status mirrors buffer state
  a_r8_avail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> !buf_avail_o);
endmodule

// File: tb/ctl_msg_mailbox_tb_top.sv
module ctl_msg_mailbox_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, sop = 1'b0, irq_en = 1'b0, fclr = 1'b0, oclr = 1'b0;
  logic [7:0]  din = '0;
  logic [63:0] mdata;
  logic        full, irq, ovr, avail;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit exp_full = 0;
  logic [63:0] exp_q[$];
  logic [63:0] last_stored = '0;
  logic full_prev = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ctl_msg_mailbox dut_i (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(valid), .byte_sop_i(sop),
    .byte_data_i(din), .irq_en_i(irq_en), .full_clr_i(fclr), .ovr_clr_i(oclr),
    .msg_data_o(mdata), .full_o(full), .irq_o(irq), .ovr_o(ovr), .buf_avail_o(avail)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: n bytes of d, first with sop; pushes expected when bench model accepts
  task automatic send(input logic [63:0] d, input int n, input bit with_sop, input bit gap);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      valid = 1'b1; sop = with_sop && (i == 0); din = d[i*8 +: 8];
      if (gap && i < n - 1) begin
        @(posedge clk); #1; valid = 1'b0; sop = 1'b0;
      end
    end
    @(posedge clk); #1;
    valid = 1'b0; sop = 1'b0;
    if (with_sop && n == 8) begin
      if (!exp_full) begin exp_q.push_back(d); exp_full = 1; end
    end
  endtask

  task automatic release_buf();
    @(posedge clk); #1 fclr = 1'b1;
    @(posedge clk); #1 fclr = 1'b0;
    exp_full = 0;
  endtask

  // monitor: on each new full event pop and compare
  always @(negedge clk) begin
    if (rst_n) begin
      if (full && !full_prev) begin
        if (exp_q.size() == 0) check(1'b0, "R3 unexpected full", 64'(full), 64'd0);
        else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          check(mdata == e, "R2 stored message", mdata, e);
          last_stored = e;
        end
      end
      full_prev <= full;
    end
  end

  initial begin
    #4_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(!full && !ovr && !irq && avail, "R1 flags", {ovr, irq, avail, full}, 64'b0010);
    check(mdata == 64'd0, "R1 data", mdata, 64'd0);
    #1 rst_n = 1'b1;

    // R2/R3 basic message
    send(64'h8877665544332211, 8, 1, 0);
    check(full, "R3 full after eighth byte", 64'(full), 64'd1);
    check(!avail, "R8 avail low when full", 64'(avail), 64'd0);
    check(!irq, "R7 irq masked", 64'(irq), 64'd0);
    @(posedge clk); #1 irq_en = 1'b1;
    @(negedge clk);
    check(irq, "R7 irq enabled", 64'(irq), 64'd1);

    // R5 message while full is dropped
    send(64'hDEADBEEFCAFEF00D, 8, 1, 0);
    @(negedge clk);
    check(mdata == 64'h8877665544332211, "R5 data held", mdata, 64'h8877665544332211);
    check(full, "R5 full kept", 64'(full), 64'd1);
    check(ovr, "R9 overrun set", 64'(ovr), 64'd1);

    // R6 release
    release_buf();
    @(negedge clk);
    check(!full && avail, "R6 cleared", {avail, full}, 64'b10);
    check(!irq, "R7 irq drops", 64'(irq), 64'd0);
    check(ovr, "R9 overrun survives release", 64'(ovr), 64'd1);
    @(posedge clk); #1 oclr = 1'b1;
    @(posedge clk); #1 oclr = 1'b0;
    @(negedge clk);
    check(!ovr, "R9 overrun cleared", 64'(ovr), 64'd0);

    // R4 truncated then restart
    send(64'h0000000505040302, 5, 1, 0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!full, "R4 truncated no full", 64'(full), 64'd0);
    send(64'h0123456789ABCDEF, 8, 1, 0);
    @(negedge clk);
    check(full, "R4 restart completes", 64'(full), 64'd1);
    release_buf();

    // R4 stray bytes with no message in progress
    send(64'hFFFFFFFFFFFFFFFF, 8, 0, 0);
    @(negedge clk);
    check(!full, "R4 stray bytes ignored", 64'(full), 64'd0);

    // R2 gaps in valid, then trailing bytes after eighth
    send(64'hA1B2C3D4E5F60718, 8, 1, 1);
    @(negedge clk);
    check(full, "R2 gapped message full", 64'(full), 64'd1);
    release_buf();
    send(64'h1111111111111199, 3, 0, 0);
    @(negedge clk);
    check(!full, "R4 trailing bytes ignored", 64'(full), 64'd0);
    check(mdata == 64'hA1B2C3D4E5F60718, "R4 trailing bytes not stored", mdata, 64'hA1B2C3D4E5F60718);

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R3 all expected messages seen", 64'(exp_q.size()), 64'd0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule